// File: doc/BRIEF.md
# Overflow-Triggered Sample Record Writer

This block keeps a small bank of event counters, 48 bits wide by default. When a counter that is armed for sampling wraps past its all-ones value, the block writes one sample record into a memory buffer. A record is a run of 64-bit words on a plain word-write port. The record starts with a fixed four-word group. Optional groups follow, and each is added only when its bit in the data-configuration register is set. The first word of every record carries both the record's byte length and the configuration that produced it. Software can therefore walk the buffer without knowing how the block was set up.

A write pointer starts wherever software places the buffer and moves forward by the length of each record. Records never extend past a limit address. After a record, once the pointer is at or beyond a threshold address, a buffer-full status bit is set and the interrupt line goes high. Register contents captured at sampling time are not produced here: the instruction pointer, the timestamp and the optional payload words all arrive as input words.

Top module: `osr_top`

## Requirements
- R1: A record's first four words, at consecutive byte addresses 8 apart starting at the write pointer, are, in order: the header, `ip_in`, the applicable-counter mask (bit i set for counter i) and `tsc_in`. Both `ip_in` and `tsc_in` are latched when the record starts.
- R2: With adaptive mode on, the length in bytes is 32, plus 32 when config bit 0 (memory group) is set, plus 144 for bit 1 (general registers), plus 256 for bit 2 (vector registers), plus 24·BR_ENTRIES for bit 3 (branch entries). Every word after the fourth carries `cap_word`. Header bits [63:48] hold this length and bits [47:0] hold the configuration.
- R3: With adaptive mode off, every record is 4 words whatever the configuration register holds, and its header is {16'd32, 48'd0}.
- R4: A base write loads the write pointer. After each record the pointer advances by that record's length.
- R5: A record is dropped when pointer + length exceeds the limit. A dropped record causes no write and leaves the pointer unchanged. A record that ends exactly at the limit is written.
- R6: When a record completes with the new pointer at or above the threshold, status bit NUM_CTR (buffer full) is set. `irq` is high while any status bit is set.
- R7: A counter counts only while its count-enable bit is set. A wrap sets status bit i. A record is requested only if the counter's sample-enable bit is also set. A wrap with sampling off writes nothing.
- R8: A counter preset to all ones wraps to zero on its next event. A counter preset to zero wraps on no event within a short run.
- R9: Counters that wrap in the same cycle share one record, with all their mask bits set. Wraps that arrive while a record is being written are held and produce a further record afterwards.
- R10: Writing to the clear register clears every status bit at which the write data holds a 1, the buffer-full bit included.
- R11: Reset leaves `mem_we`, `wr_index`, `glb_status` and `irq` at zero.
- R12: Register addresses: 0 sample-enable mask, 1 count-enable mask, 2 data configuration [47:0], 3 adaptive enable (bit 0), 4 base, 5 limit, 6 threshold, 7 status clear, 8+i preset of counter i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_inc | input | NUM_CTR | One event per counter per cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 48 | Register write data |
| ip_in | input | 64 | Instruction pointer to capture |
| tsc_in | input | 64 | Timestamp to capture |
| cap_word | input | 64 | Payload word for the optional groups |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 64 | Word being written |
| wr_index | output | ADDR_W | Current write pointer |
| glb_status | output | NUM_CTR+1 | Counter overflow bits and buffer-full bit |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with three counters and two branch entries. With those values the largest record is 64 words, so every optional group, including all four together, fits in a short run. With three counters, two can wrap together while a third has sampling off or counting off. A behavioural model built from queues predicts every memory word, the pointer and the status on every cycle. Directed cases add the limit boundary, crossing the threshold and wraps that arrive while a record is being written.

// File: rtl/osr_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the sample record writer.
// Assumes 64-bit memory words and a 48-bit configuration echo in the header.
package osr_pkg;
    localparam int WORD_B  = 8;
    localparam int CFG_W   = 48;
    localparam int LEN_W   = 16;
    localparam int BASIC_W = 4;
    localparam int MEM_W   = 4;
    localparam int GPR_W   = 18;
    localparam int VEC_W   = 32;
    localparam int BR_W    = 3;
    localparam int CFG_MEM = 0;
    localparam int CFG_GPR = 1;
    localparam int CFG_VEC = 2;
    localparam int CFG_BR  = 3;
    localparam int PRE_BASE = 8;

    typedef enum logic [3:0] {
        RA_SMP  = 4'd0,
        RA_CNT  = 4'd1,
        RA_CFG  = 4'd2,
        RA_ADP  = 4'd3,
        RA_BASE = 4'd4,
        RA_LIM  = 4'd5,
        RA_THR  = 4'd6,
        RA_CLR  = 4'd7
    } reg_addr_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_st_e;
endpackage

// File: rtl/osr_ctr_bank.sv
`timescale 1ns/1ps
// Bank of wrapping event counters.
// Each counter takes a preset write (which wins over an event) and counts
// only while enabled. It reports a wrap, and a wrap that is armed for sampling.
module osr_ctr_bank #(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTR-1:0] ev_inc,
    input  logic [NUM_CTR-1:0] cnt_en,
    input  logic [NUM_CTR-1:0] smp_en,
    input  logic [NUM_CTR-1:0] pre_we,
    input  logic [CTR_W-1:0]   pre_val,
    output logic [NUM_CTR-1:0] wrap_cnt,
    output logic [NUM_CTR-1:0] wrap_smp
);
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        logic [CTR_W-1:0] cnt;
        logic             hit;

        assign hit         = ev_inc[g] && cnt_en[g] && !pre_we[g];
        assign wrap_cnt[g] = hit && (&cnt);
        assign wrap_smp[g] = wrap_cnt[g] && smp_en[g];

        // Counter register: preset first, otherwise count enabled events.
        always_ff @(posedge clk) begin
            if (!rst_n)         cnt <= '0;
            else if (pre_we[g]) cnt <= pre_val;
            else if (hit)       cnt <= cnt + 1'b1;
        end

        a_r8_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
            wrap_cnt[g] |=> (cnt == '0));
    end
endmodule

// File: rtl/osr_sizer.sv
`timescale 1ns/1ps
// Computes the record length in bytes from the group mask.
// Assumes the optional groups count only while adaptive mode is on.
module osr_sizer
    import osr_pkg::*;
#(
    parameter int BR_ENTRIES = 8
) (
    input  logic             adaptive,
    input  logic [3:0]       grp,
    output logic [LEN_W-1:0] len_b
);
    int unsigned words;

    // Sum the word counts of the enabled groups and scale to bytes.
    always_comb begin
        words = BASIC_W;
        if (adaptive) begin
            if (grp[CFG_MEM]) words += MEM_W;
            if (grp[CFG_GPR]) words += GPR_W;
            if (grp[CFG_VEC]) words += VEC_W;
            if (grp[CFG_BR])  words += BR_W * BR_ENTRIES;
        end
        len_b = LEN_W'(words * WORD_B);
    end
endmodule

// File: rtl/osr_emitter.sv
`timescale 1ns/1ps
// Turns pending sampled wraps into records, one word per cycle.
// Assumes the limit does not change while a record is being written.
// Latches the length, the configuration and the captured words at record start.
module osr_emitter
    import osr_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int ADDR_W  = 32,
    localparam int WCNT_W = LEN_W - 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTR-1:0] wrap_smp,
    input  logic [LEN_W-1:0]   rec_len,
    input  logic [CFG_W-1:0]   hdr_cfg,
    input  logic [ADDR_W-1:0]  cur_index,
    input  logic [ADDR_W-1:0]  lim,
    input  logic [63:0]        ip_in,
    input  logic [63:0]        tsc_in,
    input  logic [63:0]        cap_word,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [63:0]        mem_wdata,
    output logic               rec_done,
    output logic [ADDR_W-1:0]  rec_end
);
    emit_st_e           st;
    logic [NUM_CTR-1:0] pend;
    logic [NUM_CTR-1:0] applic;
    logic [ADDR_W-1:0]  rbase;
    logic [LEN_W-1:0]   rlen;
    logic [CFG_W-1:0]   rcfg;
    logic [63:0]        rip;
    logic [63:0]        rtsc;
    logic [WCNT_W-1:0]  widx;
    logic [WCNT_W-1:0]  nwords;
    logic [ADDR_W:0]    end_ext;
    logic               fits;
    logic               last;

    assign end_ext = {1'b0, cur_index} + (ADDR_W+1)'(rec_len);
    assign fits    = end_ext <= {1'b0, lim};
    assign nwords  = WCNT_W'(rlen >> 3);
    assign last    = widx == WCNT_W'(nwords - 1'b1);

    // Record sequencer: start, drop or step through the words of a record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; pend <= '0; applic <= '0; rbase <= '0; rlen <= '0;
            rcfg <= '0; rip <= '0; rtsc <= '0; widx <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    pend <= wrap_smp;
                    if (pend != '0 && fits) begin
                        st     <= ST_EMIT;
                        applic <= pend;
                        rbase  <= cur_index;
                        rlen   <= rec_len;
                        rcfg   <= hdr_cfg;
                        rip    <= ip_in;
                        rtsc   <= tsc_in;
                        widx   <= '0;
                    end
                end
                ST_EMIT: begin
                    pend <= pend | wrap_smp;
                    if (last) st <= ST_IDLE;
                    else      widx <= widx + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign mem_we   = st == ST_EMIT;
    assign mem_addr = rbase + ADDR_W'({widx, 3'b000});
    assign rec_done = mem_we && last;
    assign rec_end  = rbase + ADDR_W'(rlen);

    // Word selection: basic group first, then the payload for the optional groups.
    always_comb begin
        unique case (widx)
            WCNT_W'(0): mem_wdata = {rlen, rcfg};
            WCNT_W'(1): mem_wdata = rip;
            WCNT_W'(2): mem_wdata = 64'(applic);
            WCNT_W'(3): mem_wdata = rtsc;
            default:    mem_wdata = cap_word;
        endcase
    end

    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(8)));
endmodule

// File: rtl/osr_top.sv
`timescale 1ns/1ps
// Overflow-triggered sample record writer: register file, write pointer and status.
// Assumes software programs the limit and threshold before it arms any counter.
module osr_top
    import osr_pkg::*;
#(
    parameter int NUM_CTR    = 4,
    parameter int CTR_W      = 48,
    parameter int ADDR_W     = 32,
    parameter int BR_ENTRIES = 8,
    localparam int ST_W      = NUM_CTR + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTR-1:0] ev_inc,
    input  logic               reg_we,
    input  logic [3:0]         reg_addr,
    input  logic [CFG_W-1:0]   reg_wdata,
    input  logic [63:0]        ip_in,
    input  logic [63:0]        tsc_in,
    input  logic [63:0]        cap_word,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [63:0]        mem_wdata,
    output logic [ADDR_W-1:0]  wr_index,
    output logic [ST_W-1:0]    glb_status,
    output logic               irq
);
    logic [NUM_CTR-1:0] smp_en, cnt_en, pre_we, wrap_cnt, wrap_smp;
    logic [CFG_W-1:0]   cfg, hdr_cfg;
    logic               adaptive;
    logic [ADDR_W-1:0]  lim, thr, rec_end;
    logic [LEN_W-1:0]   rec_len;
    logic               rec_done;
    logic [ST_W-1:0]    st_nxt;

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_pre
        assign pre_we[g] = reg_we && (reg_addr == 4'(PRE_BASE + g));
    end

    // Control registers written through the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_en <= '0; cnt_en <= '0; cfg <= '0; adaptive <= 1'b0;
            lim <= '0; thr <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                RA_SMP:  smp_en   <= reg_wdata[NUM_CTR-1:0];
                RA_CNT:  cnt_en   <= reg_wdata[NUM_CTR-1:0];
                RA_CFG:  cfg      <= reg_wdata;
                RA_ADP:  adaptive <= reg_wdata[0];
                RA_LIM:  lim      <= reg_wdata[ADDR_W-1:0];
                RA_THR:  thr      <= reg_wdata[ADDR_W-1:0];
                default: ;
            endcase
        end
    end

    // Write pointer: a base write loads it, a finished record advances it.
    always_ff @(posedge clk) begin
        if (!rst_n)                            wr_index <= '0;
        else if (reg_we && reg_addr == RA_BASE) wr_index <= reg_wdata[ADDR_W-1:0];
        else if (rec_done)                      wr_index <= rec_end;
    end

    // Next status: clear first, then new wraps and the buffer-full event.
    always_comb begin
        st_nxt = glb_status;
        if (reg_we && reg_addr == RA_CLR) st_nxt = st_nxt & ~reg_wdata[ST_W-1:0];
        st_nxt[NUM_CTR-1:0] = st_nxt[NUM_CTR-1:0] | wrap_cnt;
        if (rec_done && rec_end >= thr) st_nxt[NUM_CTR] = 1'b1;
    end

    // Status register update.
    always_ff @(posedge clk) begin
        if (!rst_n) glb_status <= '0;
        else        glb_status <= st_nxt;
    end

    assign irq     = |glb_status;
    assign hdr_cfg = adaptive ? cfg : '0;

    osr_ctr_bank #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .ev_inc(ev_inc), .cnt_en(cnt_en), .smp_en(smp_en),
        .pre_we(pre_we), .pre_val(reg_wdata[CTR_W-1:0]),
        .wrap_cnt(wrap_cnt), .wrap_smp(wrap_smp)
    );

    osr_sizer #(.BR_ENTRIES(BR_ENTRIES)) u_size (
        .adaptive(adaptive), .grp(cfg[3:0]), .len_b(rec_len)
    );

    osr_emitter #(.NUM_CTR(NUM_CTR), .ADDR_W(ADDR_W)) u_emit (
        .clk(clk), .rst_n(rst_n), .wrap_smp(wrap_smp), .rec_len(rec_len),
        .hdr_cfg(hdr_cfg), .cur_index(wr_index), .lim(lim), .ip_in(ip_in),
        .tsc_in(tsc_in), .cap_word(cap_word), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .rec_done(rec_done), .rec_end(rec_end)
    );

    a_r5_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ({1'b0, mem_addr} + (ADDR_W+1)'(8) <= {1'b0, lim}));

    a_r6_full_from_record: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(glb_status[NUM_CTR]) |-> $past(rec_done));

    a_r10_clear_full: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RA_CLR && reg_wdata[NUM_CTR] && !rec_done)
            |=> !glb_status[NUM_CTR]);
endmodule

// File: tb/osr_top_tb.sv
`timescale 1ns/1ps
module osr_top_tb;
    localparam int NC = 3;
    localparam int AW = 32;
    localparam int BR = 2;
    localparam logic [47:0] MAXV = 48'hFFFF_FFFF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] ev_inc = '0;
    logic          reg_we = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [47:0]   reg_wdata = '0;
    logic [63:0]   ip_in = 64'h1111_2222_3333_4444;
    logic [63:0]   tsc_in = 64'h5555_6666_7777_8888;
    logic [63:0]   cap_word = 64'h0BAD_F00D_1234_0001;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_wdata;
    logic [AW-1:0] wr_index;
    logic [NC:0]   glb_status;
    logic          irq;

    osr_top #(.NUM_CTR(NC), .CTR_W(48), .ADDR_W(AW), .BR_ENTRIES(BR)) u_dut (
        .clk(clk), .rst_n(rst_n), .ev_inc(ev_inc), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ip_in(ip_in), .tsc_in(tsc_in), .cap_word(cap_word),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .wr_index(wr_index), .glb_status(glb_status), .irq(irq)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int nw = 0;
    int k = 0;
    logic prev_we = 1'b0;
    logic [63:0] rec [4];
    bit started = 0;
    bit done_flag = 0;

    // ---------------- behavioural reference model ----------------
    longint unsigned m_cnt [NC];
    bit [NC-1:0] m_se, m_ge, m_pend;
    bit [47:0]   m_cfg;
    bit          m_adp;
    longint      m_index, m_lim, m_thr, m_recend;
    bit [NC:0]   m_stat;
    logic [31:0] qa [$];
    logic [63:0] qd [$];

    function automatic int exp_len(bit adp, bit [3:0] g);
        int w = 4;
        if (adp) begin
            if (g[0]) w += 4;
            if (g[1]) w += 18;
            if (g[2]) w += 32;
            if (g[3]) w += 3 * BR;
        end
        return 8 * w;
    endfunction

    always @(posedge clk) begin
        bit [NC-1:0] w, s;
        bit fin;
        int len;
        started <= 1;
        if (!rst_n) begin
            for (int i = 0; i < NC; i++) m_cnt[i] = 0;
            m_se = 0; m_ge = 0; m_pend = 0; m_cfg = 0; m_adp = 0;
            m_index = 0; m_lim = 0; m_thr = 0; m_recend = 0; m_stat = 0;
            qa.delete(); qd.delete();
        end else begin
            fin = 0;
            for (int i = 0; i < NC; i++)
                w[i] = ev_inc[i] && m_ge[i] && !(reg_we && reg_addr == 4'(8 + i))
                       && (m_cnt[i] == longint'(MAXV));
            s = w & m_se;
            if (qa.size() > 0) begin
                void'(qa.pop_front()); void'(qd.pop_front());
                if (qa.size() == 0) fin = 1;
                m_pend |= s;
            end else if (m_pend != 0) begin
                len = exp_len(m_adp, m_cfg[3:0]);
                if (m_index + len <= m_lim) begin
                    for (int j = 0; j < len / 8; j++) begin
                        qa.push_back(32'(m_index + 8 * j));
                        case (j)
                            0: qd.push_back({16'(len), (m_adp ? m_cfg : 48'd0)});
                            1: qd.push_back(ip_in);
                            2: qd.push_back(64'(m_pend));
                            3: qd.push_back(tsc_in);
                            default: qd.push_back(cap_word);
                        endcase
                    end
                    m_recend = m_index + len;
                end
                m_pend = s;
            end else m_pend = s;
            if (reg_we && reg_addr == 4'd7) m_stat &= ~reg_wdata[NC:0];
            m_stat[NC-1:0] |= w;
            if (fin && m_recend >= m_thr) m_stat[NC] = 1;
            if (fin) m_index = m_recend;
            if (reg_we) begin
                case (reg_addr)
                    4'd0: m_se = reg_wdata[NC-1:0];
                    4'd1: m_ge = reg_wdata[NC-1:0];
                    4'd2: m_cfg = reg_wdata;
                    4'd3: m_adp = reg_wdata[0];
                    4'd4: m_index = longint'(reg_wdata[31:0]);
                    4'd5: m_lim = longint'(reg_wdata[31:0]);
                    4'd6: m_thr = longint'(reg_wdata[31:0]);
                    default: ;
                endcase
            end
            for (int i = 0; i < NC; i++) begin
                if (reg_we && reg_addr == 4'(8 + i)) m_cnt[i] = longint'(reg_wdata);
                else if (ev_inc[i] && m_ge[i])
                    m_cnt[i] = (m_cnt[i] == longint'(MAXV)) ? 0 : m_cnt[i] + 1;
            end
        end
    end

    // Per-cycle comparison against the model, plus record word logging.
    always @(negedge clk) begin
        bit ok, ew;
        if (started && !done_flag) begin
            ew = qa.size() > 0;
            ok = (mem_we === ew) && (wr_index === 32'(m_index)) &&
                 (glb_status === m_stat) && (irq === (|m_stat));
            if (ok && ew) ok = (mem_addr === qa[0]) && (mem_wdata === qd[0]);
            n_chk++;
            if (!ok) begin
                n_fail++;
                $display("FAIL R1 R4 R6 cycle model: actual we=%b addr=%h data=%h idx=%h st=%b expected we=%b addr=%h data=%h idx=%h st=%b",
                         mem_we, mem_addr, mem_wdata, wr_index, glb_status, ew,
                         ew ? qa[0] : 32'h0, ew ? qd[0] : 64'h0, 32'(m_index), m_stat);
            end
            if (mem_we) begin
                if (!prev_we) k = 0;
                if (k < 4) rec[k] = mem_wdata;
                k++;
                nw++;
            end
            prev_we = mem_we;
        end
    end

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wreg(logic [3:0] a, logic [47:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic pulse(logic [NC-1:0] m);
        @(posedge clk); #1 ev_inc = m;
        @(posedge clk); #1 ev_inc = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        done_flag = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset mem_we", 64'(mem_we), 0);
        check("R11 reset wr_index", 64'(wr_index), 0);
        check("R11 reset status", 64'(glb_status), 0);
        check("R11 reset irq", 64'(irq), 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // Register map (R12) and buffer setup
        wreg(4'd5, 48'h4000);
        wreg(4'd6, 48'h3000);
        wreg(4'd4, 48'h1000);
        check("R12 R4 base loads pointer", 64'(wr_index), 64'h1000);
        wreg(4'd1, 48'h7);
        wreg(4'd0, 48'h5);

        // R3 / R8 / R1: adaptive off, full config ignored
        wreg(4'd2, 48'hF);
        wreg(4'd8, MAXV);
        nw = 0; pulse(3'b001); idle(10);
        check("R3 basic-only word count", 64'(nw), 4);
        check("R3 header", rec[0], {16'd32, 48'd0});
        check("R1 ip word", rec[1], ip_in);
        check("R1 mask word", rec[2], 64'h1);
        check("R1 tsc word", rec[3], tsc_in);
        check("R8 preset all-ones wraps", 64'(glb_status[0]), 1);
        check("R4 pointer advance", 64'(wr_index), 64'h1020);

        // R2: memory + vector groups
        wreg(4'd3, 48'h1);
        wreg(4'd2, 48'h5);
        wreg(4'd8, MAXV);
        nw = 0; pulse(3'b001); idle(60);
        check("R2 words mem+vec", 64'(nw), 64'(exp_len(1, 4'h5) / 8));
        check("R2 header mem+vec", rec[0], {16'd320, 48'h5});
        check("R4 pointer after 320", 64'(wr_index), 64'h1160);

        // R2: all groups
        wreg(4'd2, 48'hF);
        wreg(4'd8, MAXV);
        nw = 0; pulse(3'b001); idle(80);
        check("R2 words all groups", 64'(nw), 64);
        check("R2 header all groups", rec[0], {16'd512, 48'hF});
        check("R4 pointer after 512", 64'(wr_index), 64'h1360);

        // R7: sampling off on counter 1, then counting off on counter 2
        wreg(4'd9, MAXV);
        nw = 0; pulse(3'b010); idle(5);
        check("R7 sample-off writes nothing", 64'(nw), 0);
        check("R7 sample-off sets status", 64'(glb_status[1]), 1);
        wreg(4'd1, 48'h3);
        wreg(4'd10, MAXV);
        pulse(3'b100); idle(5);
        check("R7 count-off no wrap", 64'(glb_status[2]), 0);
        check("R7 count-off no record", 64'(nw), 0);
        wreg(4'd1, 48'h7);

        // R10: clear all status
        wreg(4'd7, 48'hF);
        check("R10 status cleared", 64'(glb_status), 0);
        check("R10 irq low", 64'(irq), 0);

        // R8: preset zero does not wrap
        wreg(4'd8, 48'd0);
        for (int i = 0; i < 20; i++) pulse(3'b001);
        idle(3);
        check("R8 zero preset no wrap", 64'(glb_status[0]), 0);
        check("R8 zero preset no record", 64'(nw), 0);

        // R9: same-cycle wraps share a record
        wreg(4'd8, MAXV);
        wreg(4'd10, MAXV);
        nw = 0; pulse(3'b101); idle(70);
        check("R9 one shared record", 64'(nw), 64);
        check("R9 shared mask", rec[2], 64'h5);

        // R9: wrap during a record is serviced afterwards
        wreg(4'd8, MAXV);
        wreg(4'd10, MAXV);
        nw = 0; pulse(3'b001); idle(5); pulse(3'b100); idle(150);
        check("R9 pending record written", 64'(nw), 128);
        check("R9 pending mask", rec[2], 64'h4);
        check("R4 pointer after two", 64'(wr_index), 64'h1960);

        // R6: threshold reached
        wreg(4'd2, 48'h0);
        wreg(4'd6, 48'h1980);
        wreg(4'd8, MAXV);
        pulse(3'b001); idle(10);
        check("R6 buffer-full bit", 64'(glb_status[NC]), 1);
        check("R6 irq raised", 64'(irq), 1);
        wreg(4'd7, 48'h8);
        check("R10 buffer-full cleared", 64'(glb_status[NC]), 0);

        // R5: does not fit, then exactly fits
        wreg(4'd5, 48'h199F);
        wreg(4'd8, MAXV);
        nw = 0; pulse(3'b001); idle(10);
        check("R5 dropped no write", 64'(nw), 0);
        check("R5 dropped pointer kept", 64'(wr_index), 64'h1980);
        wreg(4'd5, 48'h19A0);
        wreg(4'd8, MAXV);
        pulse(3'b001); idle(10);
        check("R5 exact fit written", 64'(nw), 4);
        check("R5 exact fit pointer", 64'(wr_index), 64'h19A0);

        finish_run();
    end
endmodule